// File: doc/BRIEF.md
# Priority Thread Scheduler with Counting Semaphores

This block decides, cycle by cycle, which of a set of hardware threads owns the issue slot. Each thread presents a ready flag. A thread can also be parked because it waited on a semaphore that held zero. The scheduler always picks the lowest-numbered eligible thread, so thread 0 has the highest priority. A lower thread loses the slot as soon as a higher one becomes eligible. A higher thread hands the slot down only while it is not ready or is parked on a semaphore.

A bank of counting semaphores is shared between the selected software thread and a number of hardware agents, for example I/O engines. The selected thread may signal or wait through a small opcode port. Each hardware agent has its own signal port and its own wait port. Every semaphore resolves all of its operations for a cycle in one step. Signals are summed, waits are granted in a fixed order while count plus incoming signals allows it, and the result saturates at the top of the count range.

A refused software wait parks the issuing thread. It becomes eligible again once its semaphore is non-zero, and it then re-issues the wait. A refused hardware wait is reported on that agent's grant output, and the agent retries.

Top module: `thread_sched_top`

## Requirements
- R1: While rst_ni is low and after its release, valid_o=0, tid_o=0, switch_o=0 and every semaphore count on cnt_o is 0.
- R2: A thread is eligible when its thr_ready_i bit is 1 and it is not parked. One edge after a cycle, tid_o holds the lowest-indexed thread eligible in that cycle. This includes pre-emption of a lower thread by a higher one that just became eligible.
- R3: A signal adds one to the addressed semaphore. Signals arriving in the same cycle from the software port and from several hardware agents are all added. Semaphore s is cnt_o[s*CNT_W +: CNT_W].
- R4: Counts saturate at 2**CNT_W-1 and never wrap.
- R5: A wait is granted when the count plus the signals arriving this cycle, less the waits already granted this cycle on that semaphore, is non-zero. A granted wait subtracts one. A signal and a wait together leave the count unchanged and grant the wait.
- R6: A software wait that is not granted parks the selected thread, which is not selected again until its semaphore count is non-zero.
- R7: hw_wait_ok_o[h] is combinational and is 1 exactly when agent h's wait is granted this cycle. A refused hardware wait leaves the count unchanged.
- R8: When waits compete for one semaphore, the software wait is granted first, then hardware agents in ascending index.
- R9: switch_o is 1 for one cycle exactly when tid_o differs from its value in the previous cycle.
- R10: When no thread is eligible, valid_o is 0 on the next cycle and tid_o keeps its last value.
- R11: sw_op_i uses 2'b01 for signal, 2'b10 for wait, and any other code for no operation. The sw_op_i and sw_sem_i inputs are ignored while valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_ready_i | input | NUM_THREADS | Per-thread ready flags |
| sw_op_i | input | 2 | Semaphore operation of the selected thread |
| sw_sem_i | input | SEM_W | Semaphore addressed by the selected thread |
| hw_sig_i | input | NUM_HW | Hardware signal strobes |
| hw_sig_sem_i | input | NUM_HW*SEM_W | Semaphore index per hardware signal |
| hw_wait_i | input | NUM_HW | Hardware wait requests |
| hw_wait_sem_i | input | NUM_HW*SEM_W | Semaphore index per hardware wait |
| hw_wait_ok_o | output | NUM_HW | Hardware wait granted this cycle |
| cnt_o | output | NUM_SEMS*CNT_W | Current semaphore counts |
| tid_o | output | TID_W | Selected thread |
| valid_o | output | 1 | A thread is selected |
| switch_o | output | 1 | Selected thread changed |

## Verification
The assertions check selection on every cycle. The chosen thread must have been ready and not parked. No lower-indexed thread may have been eligible. valid_o must follow whether any thread was eligible. The switch pulse must match a change of tid_o, the thread must be held while idle, and no hardware grant may appear without a request. The bench scenarios are needed to show the semaphore arithmetic: summed signals, saturation at the top of the range, and the grant order between software and hardware waiters. They also show that a parked thread wakes only after a signal, and that software operations are dropped while no thread is selected.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SIG  = 2'b01,
    OP_WAIT = 2'b10,
    OP_RSVD = 2'b11
  } sem_op_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    // scan downwards so the lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int NA = 3,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NA-1:0] sig_hit_i,
  input  logic [NA-1:0] wait_hit_i,
  output logic [NA-1:0] grant_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  localparam int AW = CW + $clog2(NA + 1) + 1;
  localparam logic [AW-1:0] MAXV = AW'({CW{1'b1}});

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] avail;

  always_comb begin
    avail = AW'(cnt_q);
    for (int a = 0; a < NA; a++) avail = avail + AW'(sig_hit_i[a]);
    grant_o = '0;
    // agent 0 (software) first, then hardware agents ascending
    for (int a = 0; a < NA; a++) begin
      if (wait_hit_i[a] && avail != '0) begin
        grant_o[a] = 1'b1;
        avail      = avail - AW'(1);
      end
    end
    cnt_nxt_o = (avail > MAXV) ? {CW{1'b1}} : avail[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/thread_sched_top.sv
module thread_sched_top #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SEMS    = 8,
  parameter int CNT_W       = 8,
  parameter int NUM_HW      = 2,
  parameter int SEM_W       = $clog2(NUM_SEMS),
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_THREADS-1:0]    thr_ready_i,
  input  logic [1:0]                sw_op_i,
  input  logic [SEM_W-1:0]          sw_sem_i,
  input  logic [NUM_HW-1:0]         hw_sig_i,
  input  logic [NUM_HW*SEM_W-1:0]   hw_sig_sem_i,
  input  logic [NUM_HW-1:0]         hw_wait_i,
  input  logic [NUM_HW*SEM_W-1:0]   hw_wait_sem_i,
  output logic [NUM_HW-1:0]         hw_wait_ok_o,
  output logic [NUM_SEMS*CNT_W-1:0] cnt_o,
  output logic [TID_W-1:0]          tid_o,
  output logic                      valid_o,
  output logic                      switch_o
);
  import sched_pkg::*;

  localparam int NA = NUM_HW + 1;

  logic [TID_W-1:0]       tid_q;
  logic                   valid_q, switch_q;
  logic [NUM_THREADS-1:0] blocked_q, blocked_d;
  logic [SEM_W-1:0]       bsem_q [NUM_THREADS];
  logic [SEM_W-1:0]       bsem_d [NUM_THREADS];

  logic                   sw_act, sw_is_sig, sw_is_wait, sw_grant;
  logic [NA-1:0]          grant_s [NUM_SEMS];
  logic [CNT_W-1:0]       cnt_nxt [NUM_SEMS];

  logic [TID_W-1:0]       pick_idx;
  logic                   pick_any;

  assign sw_act     = valid_q;
  assign sw_is_sig  = sw_act && (sem_op_e'(sw_op_i) == OP_SIG);
  assign sw_is_wait = sw_act && (sem_op_e'(sw_op_i) == OP_WAIT);

  for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
    logic [NA-1:0] sig_hit, wait_hit;

    always_comb begin
      sig_hit[0]  = sw_is_sig  && (sw_sem_i == SEM_W'(s));
      wait_hit[0] = sw_is_wait && (sw_sem_i == SEM_W'(s));
      for (int h = 0; h < NUM_HW; h++) begin
        sig_hit[h+1]  = hw_sig_i[h]  && (hw_sig_sem_i[h*SEM_W +: SEM_W]  == SEM_W'(s));
        wait_hit[h+1] = hw_wait_i[h] && (hw_wait_sem_i[h*SEM_W +: SEM_W] == SEM_W'(s));
      end
    end

    sem_cell #(.NA(NA), .CW(CNT_W)) i_sem_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sig_hit_i (sig_hit),
      .wait_hit_i(wait_hit),
      .grant_o   (grant_s[s]),
      .cnt_o     (cnt_o[s*CNT_W +: CNT_W]),
      .cnt_nxt_o (cnt_nxt[s])
    );
  end

  always_comb begin
    sw_grant     = 1'b0;
    hw_wait_ok_o = '0;
    for (int s = 0; s < NUM_SEMS; s++) begin
      sw_grant = sw_grant | grant_s[s][0];
      for (int h = 0; h < NUM_HW; h++) hw_wait_ok_o[h] = hw_wait_ok_o[h] | grant_s[s][h+1];
    end
  end

  // park / wake
  always_comb begin
    blocked_d = blocked_q;
    for (int t = 0; t < NUM_THREADS; t++) begin
      bsem_d[t] = bsem_q[t];
      if (blocked_q[t] && cnt_nxt[bsem_q[t]] != '0) blocked_d[t] = 1'b0;
    end
    if (sw_is_wait && !sw_grant) begin
      blocked_d[tid_q] = 1'b1;
      bsem_d[tid_q]    = sw_sem_i;
    end
  end

  prio_pick #(.N(NUM_THREADS), .IW(TID_W)) i_prio_pick (
    .req_i(thr_ready_i & ~blocked_d),
    .idx_o(pick_idx),
    .any_o(pick_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tid_q     <= '0;
      valid_q   <= 1'b0;
      switch_q  <= 1'b0;
      blocked_q <= '0;
      for (int t = 0; t < NUM_THREADS; t++) bsem_q[t] <= '0;
    end else begin
      blocked_q <= blocked_d;
      for (int t = 0; t < NUM_THREADS; t++) bsem_q[t] <= bsem_d[t];
      valid_q <= pick_any;
      if (pick_any) begin
        tid_q    <= pick_idx;
        switch_q <= (pick_idx != tid_q);
      end else begin
        switch_q <= 1'b0;
      end
    end
  end

  assign tid_o    = tid_q;
  assign valid_o  = valid_q;
  assign switch_o = switch_q;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NT = 8,
  parameter int NH = 2,
  parameter int TW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NT-1:0] thr_ready_i,
  input logic [NT-1:0] blk_i,
  input logic [NH-1:0] hw_wait_i,
  input logic [NH-1:0] hw_wait_ok_o,
  input logic [TW-1:0] tid_o,
  input logic          valid_o,
  input logic          switch_o
);
  logic [NT-1:0] rdy_q, elig, low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= '0;
    else         rdy_q <= thr_ready_i;
  end

  assign elig     = rdy_q & ~blk_i;
  assign low_mask = (NT'(1) << tid_o) - NT'(1);

  assert_sel_eligible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig[tid_o]);

  assert_no_higher_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((elig & low_mask) == '0));

  assert_valid_tracks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (elig != '0));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(tid_o));

  assert_pulse_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> (tid_o != $past(tid_o)));

  assert_change_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tid_o != $past(tid_o)) |-> switch_o);

  assert_grant_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_wait_ok_o & ~hw_wait_i) == '0);
endmodule

bind thread_sched_top sched_checker #(
  .NT(NUM_THREADS), .NH(NUM_HW), .TW(TID_W)
) i_sched_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .thr_ready_i (thr_ready_i),
  .blk_i       (blocked_q),
  .hw_wait_i   (hw_wait_i),
  .hw_wait_ok_o(hw_wait_ok_o),
  .tid_o       (tid_o),
  .valid_o     (valid_o),
  .switch_o    (switch_o)
);

// File: tb/test_thread_sched_top.sv
`timescale 1ns/1ps
module test_thread_sched_top;
  localparam int NT = 8, NS = 8, CW = 8, NH = 2, SW = 3, TW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NT-1:0]    thr_ready_i = '0;
  logic [1:0]       sw_op_i = '0;
  logic [SW-1:0]    sw_sem_i = '0;
  logic [NH-1:0]    hw_sig_i = '0;
  logic [NH*SW-1:0] hw_sig_sem_i = '0;
  logic [NH-1:0]    hw_wait_i = '0;
  logic [NH*SW-1:0] hw_wait_sem_i = '0;
  logic [NH-1:0]    hw_wait_ok_o;
  logic [NS*CW-1:0] cnt_o;
  logic [TW-1:0]    tid_o;
  logic             valid_o, switch_o;

  thread_sched_top i_thread_sched_top (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 1'b0;

  int m_cnt [NS];
  int nxt_cnt [NS];
  bit m_blk [NT];
  int m_bsem [NT];
  int m_tid;
  bit m_val, m_sw, m_swg;
  bit [NH-1:0] m_hwok, last_hwok;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int dcnt(int s);
    return int'(cnt_o[s*CW +: CW]);
  endfunction

  task automatic model_comb();
    int avail [NS];
    int s;
    for (int i = 0; i < NS; i++) avail[i] = m_cnt[i];
    if (m_val && sw_op_i == 2'b01) avail[sw_sem_i]++;
    for (int h = 0; h < NH; h++)
      if (hw_sig_i[h]) avail[hw_sig_sem_i[h*SW +: SW]]++;
    m_swg = 1'b0;
    if (m_val && sw_op_i == 2'b10) begin
      s = sw_sem_i;
      if (avail[s] > 0) begin m_swg = 1'b1; avail[s]--; end
    end
    m_hwok = '0;
    for (int h = 0; h < NH; h++) begin
      if (hw_wait_i[h]) begin
        s = hw_wait_sem_i[h*SW +: SW];
        if (avail[s] > 0) begin m_hwok[h] = 1'b1; avail[s]--; end
      end
    end
    for (int i = 0; i < NS; i++) nxt_cnt[i] = (avail[i] > MAXC) ? MAXC : avail[i];
  endtask

  task automatic model_seq(input logic [NT-1:0] rdy, input logic [1:0] op, input int sem);
    int pick;
    for (int t = 0; t < NT; t++)
      if (m_blk[t] && nxt_cnt[m_bsem[t]] != 0) m_blk[t] = 1'b0;
    if (m_val && op == 2'b10 && !m_swg) begin
      m_blk[m_tid] = 1'b1;
      m_bsem[m_tid] = sem;
    end
    for (int i = 0; i < NS; i++) m_cnt[i] = nxt_cnt[i];
    pick = -1;
    for (int t = NT - 1; t >= 0; t--) if (rdy[t] && !m_blk[t]) pick = t;
    if (pick >= 0) begin
      m_sw = (pick != m_tid);
      m_tid = pick;
      m_val = 1'b1;
    end else begin
      m_sw = 1'b0;
      m_val = 1'b0;
    end
  endtask

  task automatic cyc(input logic [NT-1:0] rdy, input logic [1:0] op, input int sem,
                     input logic [NH-1:0] hs, input int hs0, input int hs1,
                     input logic [NH-1:0] hw, input int hw0, input int hw1);
    @(negedge clk_i);
    thr_ready_i   = rdy;
    sw_op_i       = op;
    sw_sem_i      = SW'(sem);
    hw_sig_i      = hs;
    hw_sig_sem_i  = {SW'(hs1), SW'(hs0)};
    hw_wait_i     = hw;
    hw_wait_sem_i = {SW'(hw1), SW'(hw0)};
    #1;
    model_comb();
    last_hwok = hw_wait_ok_o;
    chk("R7 hw_wait_ok", int'(hw_wait_ok_o), int'(m_hwok));
    @(posedge clk_i);
    #1;
    model_seq(rdy, op, sem);
    chk("R2 tid", int'(tid_o), m_tid);
    chk("R2 valid", int'(valid_o), int'(m_val));
    chk("R9 switch", int'(switch_o), int'(m_sw));
    for (int i = 0; i < NS; i++) chk("R3 count", dcnt(i), m_cnt[i]);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin m_cnt[i] = 0; nxt_cnt[i] = 0; end
    for (int t = 0; t < NT; t++) begin m_blk[t] = 1'b0; m_bsem[t] = 0; end
    m_tid = 0; m_val = 1'b0; m_sw = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 tid in reset", int'(tid_o), 0);
    chk("R1 switch in reset", int'(switch_o), 0);
    chk("R1 counts in reset", int'(cnt_o != '0), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R11: software op dropped while nothing selected
    cyc('0, 2'b01, 0, '0, 0, 0, '0, 0, 0);
    chk("R11 ignored signal", dcnt(0), 0);

    // R4: two agents signal sem 5 repeatedly
    for (int k = 0; k < 130; k++) cyc('0, 2'b00, 0, 2'b11, 5, 5, '0, 0, 0);
    chk("R4 saturated", dcnt(5), MAXC);

    // R5: simultaneous signal and wait on empty sem 3
    cyc('0, 2'b00, 0, 2'b01, 3, 0, 2'b10, 0, 3);
    chk("R5 grant with signal", int'(last_hwok[1]), 1);
    chk("R5 net count", dcnt(3), 0);

    // R6: thread 2 waits on empty sem 1
    cyc(8'b0000_0100, 2'b00, 0, '0, 0, 0, '0, 0, 0);
    chk("R2 single ready", int'(tid_o), 2);
    cyc(8'b0000_0100, 2'b10, 1, '0, 0, 0, '0, 0, 0);
    chk("R6 parked", int'(valid_o), 0);
    chk("R10 tid held", int'(tid_o), 2);
    cyc(8'b0000_0100, 2'b00, 0, '0, 0, 0, '0, 0, 0);
    chk("R6 stays parked", int'(valid_o), 0);
    cyc(8'b0000_0100, 2'b00, 0, 2'b01, 1, 0, '0, 0, 0);
    chk("R6 woken", int'(valid_o), 1);
    cyc(8'b0000_0100, 2'b10, 1, '0, 0, 0, '0, 0, 0);
    chk("R5 decrement", dcnt(1), 0);
    chk("R5 no park", int'(valid_o), 1);

    // R2 pre-emption and R9 pulse
    cyc(8'b0000_0110, 2'b00, 0, '0, 0, 0, '0, 0, 0);
    chk("R2 preempt", int'(tid_o), 1);
    chk("R9 pulse", int'(switch_o), 1);
    cyc(8'b0000_0110, 2'b00, 0, '0, 0, 0, '0, 0, 0);
    chk("R9 single pulse", int'(switch_o), 0);

    // R8: one token, software and hardware compete
    cyc(8'b0000_0010, 2'b00, 0, 2'b01, 4, 0, '0, 0, 0);
    cyc(8'b0000_0010, 2'b10, 4, '0, 0, 0, 2'b10, 0, 4);
    chk("R8 hw loses", int'(last_hwok[1]), 0);
    chk("R8 sw wins", int'(valid_o), 1);
    chk("R8 count", dcnt(4), 0);

    // R7: refused hardware wait
    cyc('0, 2'b00, 0, '0, 0, 0, 2'b01, 6, 0);
    chk("R7 refused", int'(last_hwok[0]), 0);
    chk("R7 count kept", dcnt(6), 0);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      logic [NT-1:0] rdy;
      rdy = NT'($urandom & $urandom);
      if ($urandom % 16 == 0) rdy = '0;
      cyc(rdy, 2'($urandom), ($urandom % 2) ? $urandom % 4 : $urandom % 8,
          NH'($urandom), $urandom % 4, $urandom % 8,
          NH'($urandom), $urandom % 4, $urandom % 8);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule